// File: doc/BRIEF.md
# Cascadable Display Serial Register Interface

This block is the serial front end of a dot-matrix display driver. A host drives a data line, a shift clock, an active-low chip enable and a register-select line. Everything is sampled into a single system clock domain. The select line is captured when chip enable falls. Each rising shift-clock edge seen while chip enable is low moves one bit into either a dot shift register or an 8-bit control shift register. When chip enable rises, the addressed shift register is copied into its holding register. For control words, bit D7 picks between the two control words.

A shift-out pin carries data on to the next device in a chain. During dot writes it is the last stage of the dot shift register, so chained dot registers form one long register. During control writes it is either the top control stage (serial mode) or a combinational copy of the data input (simultaneous mode). Simultaneous mode lets every device in a chain take the same control word in 8 shift clocks rather than N×8. The dot image, control word 0, the prescale bit and a configuration error flag are exported to the refresh logic.

Top module: `disp_serial_if`

## Requirements
- R1: A synchronous active-low reset clears the dot image, control word 0, the prescale bit, the simultaneous-mode bit and the error flag, and drives the shift-out pin low.
- R2: The register-select line is sampled when chip enable falls: 1 selects the control register and 0 selects the dot register. Changing it later in the same frame has no effect.
- R3: Bits shift in MSB first, one per rising shift-clock edge while chip enable is low. Shift-clock edges seen while chip enable is high are ignored.
- R4: Holding registers change only on the rising edge of chip enable. After a dot frame the dot image equals the last DOT_BITS bits shifted in, with the first of them at the top.
- R5: A latched control word with D7 = 0 stores D6..D0 in control word 0 and leaves the control word 1 fields unchanged.
- R6: A latched control word with D7 = 1 stores D0 as the simultaneous-mode bit and D1 as the prescale bit, and leaves control word 0 unchanged.
- R7: On each latch of a D7 = 1 word, the error flag is set to the OR of D2..D6. D0 and D1 are stored either way, and a clean word clears the flag.
- R8: In serial mode during a control frame, shift-out is the top control shift stage. N chained devices then receive their own words after N×8 shift clocks, with the first-sent byte ending in the farthest device.
- R9: In simultaneous mode during a control frame, shift-out equals the data input combinationally. All chained devices then latch the same word after 8 shift clocks.
- R10: During a dot frame, shift-out is the last dot stage whatever the mode. For two chained devices, a 2×DOT_BITS frame leaves the first-sent half in the far device.
- R11: While chip enable is high, shift-out follows the top stage of the register chosen by the last frame, with no pass-through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial shift clock, sampled |
| ce_n_i | input | 1 | Active-low chip enable |
| rs_i | input | 1 | Register select: 1 control, 0 dot |
| din_i | input | 1 | Serial data input |
| dout_o | output | 1 | Serial data output to the next device |
| dot_image_o | output | DOT_BITS | Latched dot image |
| ctrl0_o | output | CTRL_BITS-1 | Latched control word 0 payload (D6..D0) |
| prescale_o | output | 1 | Control word 1 bit D1 |
| cfg_err_o | output | 1 | Reserved bits D2..D6 were nonzero on last control word 1 latch |

## Verification
The bench builds two instances with DOT_BITS = 16 and chains the shift-out of the first into the data input of the second. This shrinks a full cascaded dot frame to 32 shift clocks. Chained serial control loading, simultaneous broadcast and the boundary between the two devices' halves can then all be checked against directly computed words. CTRL_BITS stays at 8, because the D7, D1, D0 and reserved-field decoding depends on that width.

// File: rtl/disp_ser_pkg.sv
package disp_ser_pkg;
   typedef enum logic {
      SEL_DOT  = 1'b0,
      SEL_CTRL = 1'b1
   } reg_sel_e;

   typedef struct packed {
      logic simul;
      logic prescale;
      logic err;
   } cw1_t;
endpackage

// File: rtl/dsi_edge_det.sv
module dsi_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic ce_n_i,
   output logic sclk_rise,
   output logic ce_fall,
   output logic ce_rise
);
   logic sclk_q;
   logic ce_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_q <= 1'b1;
         ce_q   <= 1'b1;
      end else begin
         sclk_q <= sclk_i;
         ce_q   <= ce_n_i;
      end
   end

   assign sclk_rise = sclk_i & ~sclk_q;
   assign ce_fall   = ce_q & ~ce_n_i;
   assign ce_rise   = ~ce_q & ce_n_i;
endmodule

// File: rtl/dsi_shift_reg.sv
module dsi_shift_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             bit_in,
   output logic [WIDTH-1:0] q,
   output logic             msb
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("dsi_shift_reg: WIDTH must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= {q[WIDTH-2:0], bit_in};
   end

   assign msb = q[WIDTH-1];
endmodule

// File: rtl/dsi_ctrl_decode.sv
module dsi_ctrl_decode
   import disp_ser_pkg::*;
#(
   parameter int CTRL_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 latch_en,
   input  logic [CTRL_BITS-1:0] word,
   output logic [CTRL_BITS-2:0] ctrl0,
   output cw1_t                 cw1
);
   localparam int SEL_BIT  = CTRL_BITS - 1;
   localparam int RSVD_LO  = 2;
   localparam int RSVD_HI  = CTRL_BITS - 2;

   generate
      if (CTRL_BITS != 8) begin : g_bad_ctrl
         $error("dsi_ctrl_decode: control field layout needs CTRL_BITS == 8");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl0 <= '0;
         cw1   <= '0;
      end else if (latch_en) begin
         if (word[SEL_BIT]) begin
            cw1.simul    <= word[0];
            cw1.prescale <= word[1];
            cw1.err      <= |word[RSVD_HI:RSVD_LO];
         end else begin
            ctrl0 <= word[CTRL_BITS-2:0];
         end
      end
   end
endmodule

// File: rtl/disp_serial_if.sv
module disp_serial_if
   import disp_ser_pkg::*;
#(
   parameter int DOT_BITS  = 160,
   parameter int CTRL_BITS = 8,
   parameter bit SIMUL_EN  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sclk_i,
   input  logic                 ce_n_i,
   input  logic                 rs_i,
   input  logic                 din_i,
   output logic                 dout_o,
   output logic [DOT_BITS-1:0]  dot_image_o,
   output logic [CTRL_BITS-2:0] ctrl0_o,
   output logic                 prescale_o,
   output logic                 cfg_err_o
);
   generate
      if (DOT_BITS < 2) begin : g_bad_dot
         $error("disp_serial_if: DOT_BITS must be at least 2");
      end
   endgenerate

   logic                 sclk_rise, ce_fall, ce_rise;
   reg_sel_e             sel_lat;
   reg_sel_e             cur_sel;
   logic                 cur_sel_ctrl;
   logic                 shift_en;
   logic [DOT_BITS-1:0]  dot_q;
   logic                 dot_msb;
   logic [CTRL_BITS-1:0] ctrl_q;
   logic                 ctrl_msb;
   logic                 ctrl_out;
   cw1_t                 cw1;
   logic                 cw1_simul;

   dsi_edge_det i_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_i    (sclk_i),
      .ce_n_i    (ce_n_i),
      .sclk_rise (sclk_rise),
      .ce_fall   (ce_fall),
      .ce_rise   (ce_rise)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       sel_lat <= SEL_DOT;
      else if (ce_fall) sel_lat <= reg_sel_e'(rs_i);
   end

   assign cur_sel      = ce_fall ? reg_sel_e'(rs_i) : sel_lat;
   assign cur_sel_ctrl = (cur_sel == SEL_CTRL);
   assign shift_en     = sclk_rise & ~ce_n_i;

   dsi_shift_reg #(.WIDTH(DOT_BITS)) i_dot_sr (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (shift_en & ~cur_sel_ctrl),
      .bit_in (din_i),
      .q      (dot_q),
      .msb    (dot_msb)
   );

   dsi_shift_reg #(.WIDTH(CTRL_BITS)) i_ctrl_sr (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (shift_en & cur_sel_ctrl),
      .bit_in (din_i),
      .q      (ctrl_q),
      .msb    (ctrl_msb)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                             dot_image_o <= '0;
      else if (ce_rise && sel_lat == SEL_DOT) dot_image_o <= dot_q;
   end

   dsi_ctrl_decode #(.CTRL_BITS(CTRL_BITS)) i_decode (
      .clk      (clk),
      .rst_n    (rst_n),
      .latch_en (ce_rise && sel_lat == SEL_CTRL),
      .word     (ctrl_q),
      .ctrl0    (ctrl0_o),
      .cw1      (cw1)
   );

   assign cw1_simul  = cw1.simul;
   assign prescale_o = cw1.prescale;
   assign cfg_err_o  = cw1.err;

   generate
      if (SIMUL_EN) begin : g_pass
         assign ctrl_out = (~ce_n_i & cw1_simul) ? din_i : ctrl_msb;
      end else begin : g_serial_only
         assign ctrl_out = ctrl_msb;
      end
   endgenerate

   assign dout_o = cur_sel_ctrl ? ctrl_out : dot_msb;
endmodule

// File: rtl/disp_serial_if_sva.sv
module disp_serial_if_sva #(
   parameter int DOT_BITS  = 160,
   parameter int CTRL_BITS = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 ce_n_i,
   input logic                 din_i,
   input logic                 dout_o,
   input logic [DOT_BITS-1:0]  dot_image_o,
   input logic [CTRL_BITS-2:0] ctrl0_o,
   input logic                 prescale_o,
   input logic                 cfg_err_o,
   input logic                 sel_ctrl,
   input logic                 simul
);
   // R4
   ctrl0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n_i && $past(ce_n_i)) |=> $stable(ctrl0_o));

   // R4
   dot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n_i && $past(ce_n_i)) |=> $stable(dot_image_o));

   // R6
   prescale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_n_i |=> $stable(prescale_o));

   // R7
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ce_n_i |=> $stable(cfg_err_o));

   // R9
   simul_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n_i && sel_ctrl && simul) |-> (dout_o == din_i));
endmodule

bind disp_serial_if disp_serial_if_sva #(.DOT_BITS(DOT_BITS), .CTRL_BITS(CTRL_BITS)) i_sva (
   .clk         (clk),
   .rst_n       (rst_n),
   .ce_n_i      (ce_n_i),
   .din_i       (din_i),
   .dout_o      (dout_o),
   .dot_image_o (dot_image_o),
   .ctrl0_o     (ctrl0_o),
   .prescale_o  (prescale_o),
   .cfg_err_o   (cfg_err_o),
   .sel_ctrl    (cur_sel_ctrl),
   .simul       (cw1_simul)
);

// File: tb/test_disp_serial_if.sv
`timescale 1ns/1ps
module test_disp_serial_if;
   localparam int DB = 16;
   localparam int CB = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, ce_n = 1'b1, rs = 1'b0, din = 1'b0;
   logic dout_a, dout_b;
   logic [DB-1:0] img_a, img_b;
   logic [CB-2:0] c0_a, c0_b;
   logic pre_a, pre_b, err_a, err_b;

   int total = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   disp_serial_if #(.DOT_BITS(DB), .CTRL_BITS(CB)) i_disp_serial_if (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .ce_n_i(ce_n), .rs_i(rs),
      .din_i(din), .dout_o(dout_a), .dot_image_o(img_a), .ctrl0_o(c0_a),
      .prescale_o(pre_a), .cfg_err_o(err_a));

   disp_serial_if #(.DOT_BITS(DB), .CTRL_BITS(CB)) i_disp_serial_if_nxt (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .ce_n_i(ce_n), .rs_i(rs),
      .din_i(dout_a), .dout_o(dout_b), .dot_image_o(img_b), .ctrl0_o(c0_b),
      .prescale_o(pre_b), .cfg_err_o(err_b));

   localparam logic [DB-1:0] DOT_VEC [4] = '{16'hA5F0, 16'h0001, 16'h8000, 16'hFFFF};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic frame_begin(input logic sel);
      @(negedge clk);
      rs = sel;
      ce_n = 1'b0;
      wclk(2);
   endtask

   task automatic shift_bit(input logic b);
      din = b;
      wclk(2);
      sclk = 1'b1;
      wclk(2);
      sclk = 1'b0;
      wclk(1);
   endtask

   task automatic frame_end();
      ce_n = 1'b1;
      wclk(3);
   endtask

   task automatic send_frame(input logic sel, input int n, input logic [31:0] w);
      frame_begin(sel);
      for (int i = n - 1; i >= 0; i--) shift_bit(w[i]);
      frame_end();
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin : main
      logic [DB-1:0] prev;
      wclk(4);
      // R1 reset state
      chk("R1 img_a", 32'(img_a), 0);
      chk("R1 c0_a", 32'(c0_a), 0);
      chk("R1 pre/err", {30'd0, pre_a, err_a}, 0);
      chk("R1 dout_a", 32'(dout_a), 0);
      rst_n = 1'b1;
      wclk(2);

      // R3 R4 R10: vector walk, first device gets each word, far device the previous one
      prev = '0;
      foreach (DOT_VEC[k]) begin
         send_frame(1'b0, DB, 32'(DOT_VEC[k]));
         chk("R4 dot image near", 32'(img_a), 32'(DOT_VEC[k]));
         chk("R10 dot image far", 32'(img_b), 32'(prev));
         prev = DOT_VEC[k];
      end

      // R10 cascaded dot frame
      send_frame(1'b0, 2 * DB, 32'hC3A5_1E69);
      chk("R10 chain near half", 32'(img_a), 32'h1E69);
      chk("R10 chain far half", 32'(img_b), 32'hC3A5);

      // R5 R6 R8 serial chained control words
      send_frame(1'b1, 16, 32'h2A82);
      chk("R8 far ctrl0", 32'(c0_b), 32'h2A);
      chk("R5 far prescale untouched", 32'(pre_b), 0);
      chk("R6 near prescale", 32'(pre_a), 1);
      chk("R6 near ctrl0 untouched", 32'(c0_a), 0);

      // R7 reserved bits set on near device, clean word on far device
      send_frame(1'b1, 16, 32'h80FD);
      chk("R7 near err", 32'(err_a), 1);
      chk("R7 near prescale stored", 32'(pre_a), 0);
      chk("R7 far err", 32'(err_b), 0);
      chk("R5 far ctrl0 kept", 32'(c0_b), 32'h2A);

      // R9 near device now in simultaneous mode: pass-through during control frame
      frame_begin(1'b1);
      din = 1'b1; #1;
      chk("R9 pass-through 1", 32'(dout_a), 1);
      din = 1'b0; #1;
      chk("R9 pass-through 0", 32'(dout_a), 0);
      for (int i = 7; i >= 0; i--) shift_bit(8'h81 >> i);
      frame_end();
      chk("R7 err cleared", {30'd0, err_a, err_b}, 0);

      // R9 broadcast with both devices simultaneous
      send_frame(1'b1, 8, 32'h55);
      chk("R9 broadcast near", 32'(c0_a), 32'h55);
      chk("R9 broadcast far", 32'(c0_b), 32'h55);

      // R10 dot frame in simultaneous mode: shift-out is dot stage, not din
      frame_begin(1'b0);
      din = 1'b1; #1;
      chk("R10 dot dout ignores din", 32'(dout_a), 0);
      for (int i = 31; i >= 0; i--) shift_bit(32'h0F0F_8001 >> i);
      frame_end();
      chk("R10 simul chain near", 32'(img_a), 32'h8001);
      chk("R10 simul chain far", 32'(img_b), 32'h0F0F);
      chk("R11 idle dout dot top", 32'(dout_a), 1);

      // R2 select changed mid-frame is ignored
      frame_begin(1'b1);
      rs = 1'b0;
      for (int i = 7; i >= 0; i--) shift_bit(8'h33 >> i);
      frame_end();
      chk("R2 ctrl0 near", 32'(c0_a), 32'h33);
      chk("R2 dot untouched", 32'(img_a), 32'h8001);
      chk("R11 idle dout ctrl top", 32'(dout_a), 0);

      // R3 shift clocks with chip enable high are ignored
      din = 1'b1;
      for (int i = 0; i < 4; i++) begin
         sclk = 1'b1; wclk(2);
         sclk = 1'b0; wclk(2);
      end
      chk("R3 dout unchanged", 32'(dout_a), 0);
      chk("R3 ctrl0 unchanged", 32'(c0_a), 32'h33);
      send_frame(1'b1, 8, 32'h0F);
      chk("R3 exact word after", 32'(c0_a), 32'h0F);

      // R1 reset mid-run
      @(negedge clk); rst_n = 1'b0;
      wclk(3);
      chk("R1 reset img", {img_a, img_b}, 0);
      chk("R1 reset ctrl", {18'd0, c0_a, c0_b}, 0);
      chk("R1 reset fields", {28'd0, pre_a, pre_b, err_a, err_b}, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule